// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Registers

This block is the software-visible configuration space of a DRAM controller. It is a bank of 32-bit words behind a simple single-cycle register bus. One word, the lock word at offset 0x00, must be loaded with a magic value before any other word accepts a write. Locked writes and accesses outside the bank are dropped and flagged on a one-cycle error pulse.

The configuration word at offset 0x04 carries fields that software may not change. A write merges the incoming data with a read-only mask and a fixed value. The fixed value holds the DRAM size code, which is computed at elaboration from a size parameter. A generation parameter selects between an older and a newer silicon flavour. These differ in the mask, the size encoding and the fixed fields. On the newer flavour, the PHY status word always reports idle. The ECC self-test word always reports finished without failure, whatever software writes.

Reads are registered: data appears on the cycle after the read strobe and holds until the next read.

Top module: `memctl_cfg_regs`

## Requirements
- R1: A write of 0xFC600309 to byte offset 0x00 stores 1 there; a write of any other value stores 0. Reading offset 0x00 returns that 1 or 0, and the block is unlocked while it is 1.
- R2: While offset 0x00 holds 0, a write to any other in-range offset leaves every word unchanged, and err_o is 1 on the following cycle for exactly one cycle.
- R3: With GEN=0, a write to offset 0x04 stores (data AND NOT 0xFFFFF84C) OR fixed, where the fixed value is 0x40 OR the size code.
- R4: With GEN=1, a write to offset 0x04 stores (data AND NOT 0xF00FC04C) OR fixed, where the fixed value is 0x1008000C OR the size code.
- R5: With GEN=1, a write to offset 0x60 stores bit 0 as 0, and a write to offset 0x70 stores bit 12 as 1 and bit 13 as 0. With GEN=0, both offsets store the data unchanged.
- R6: With GEN=0, the size code in bits 1:0 is 0, 1, 2 or 3 for RAM_MB of 64, 128, 256 or 512. Any other RAM_MB gives code 2.
- R7: With GEN=1, the size code in bits 1:0 is 0, 1, 2 or 3 for RAM_MB of 128, 256, 512 or 1024. Any other RAM_MB gives code 2.
- R8: After reset, every word reads 0 except offset 0x04, which reads the fixed value. rdata_o and err_o are 0, and the block is locked.
- R9: The word index is addr_i[ADDR_W-1:2]. An index at or above NUM_REGS changes no word on write and returns 0 on read. The write or read raises err_o for one cycle on the following cycle.
- R10: rdata_o takes the addressed word one cycle after rd_en_i. On a simultaneous write to the same word, it takes the value from before that write. It holds its value while rd_en_i is 0.
- R11: While unlocked, any other in-range word stores the write data as given. Address bits 1:0 play no part in selecting the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data, valid the cycle after rd_en_i |
| err_o | output | 1 | One-cycle pulse for a locked write or an out-of-range access |

## Verification
The hardest cases to reach are those where the lock state changes inside a dense stream of accesses. Examples are a relock immediately followed by a configuration write, or a read and a write to the same word in one cycle. These are reached with a long random stream over a small set of offsets, in which the magic key appears on a quarter of the data values. A behavioural model of both generations is stepped alongside and compared every cycle. An out-of-range write of 0 whose low index bits match the lock word confirms that the bank does not fold high addresses onto the lock word.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;

  localparam logic [31:0] UNLOCK_KEY   = 32'hFC60_0309;
  localparam int          CONF_IDX     = 1;
  localparam int          PHY_STAT_IDX = 24;
  localparam int          SELFTEST_IDX = 28;

  // size code of bits 1:0; unsupported sizes fall back to a common default
  function automatic logic [1:0] size_code(input int gen, input int mb);
    logic [1:0] c;
    if (gen == 0) begin
      case (mb)
        64:      c = 2'd0;
        128:     c = 2'd1;
        256:     c = 2'd2;
        512:     c = 2'd3;
        default: c = 2'd2;
      endcase
    end else begin
      case (mb)
        128:     c = 2'd0;
        256:     c = 2'd1;
        512:     c = 2'd2;
        1024:    c = 2'd3;
        default: c = 2'd2;
      endcase
    end
    return c;
  endfunction

  function automatic logic [31:0] ro_mask(input int gen);
    logic [31:0] m;
    m = 32'h0000_004C;                 // aperture 3:2, compat bit 6
    if (gen == 0) m |= 32'hFFFF_F800;  // reserved 31:11
    else          m |= 32'hF00F_C000;  // version 31:28, init-done 19, reserved 18:14
    return m;
  endfunction

  function automatic logic [31:0] fixed_conf(input int gen, input int mb);
    logic [31:0] f;
    if (gen == 0) f = 32'h0000_0040;
    else          f = 32'h1008_000C;
    f[1:0] = size_code(gen, mb);
    return f;
  endfunction

endpackage

// File: rtl/memctl_cfg_decode.sv
module memctl_cfg_decode #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 64,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              in_range_o,
  output logic              is_key_o
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W + 1)'(NUM_REGS);

  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  assign idx_o      = addr_i[ADDR_W-1:2];
  assign in_range_o = {1'b0, idx_o} < LIMIT;
  assign is_key_o   = (idx_o == '0);
endmodule

// File: rtl/memctl_cfg_shape.sv
module memctl_cfg_shape
  import memctl_cfg_pkg::*;
#(
  parameter int GEN    = 1,
  parameter int RAM_MB = 512,
  parameter int IDX_W  = 10
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      wdata_o
);
  localparam logic [31:0] MASK  = ro_mask(GEN);
  localparam logic [31:0] FIXED = fixed_conf(GEN, RAM_MB);

  logic [31:0] merged;

  always_comb begin
    merged = wdata_i;
    if (idx_i == IDX_W'(CONF_IDX)) merged = (wdata_i & ~MASK) | FIXED;
  end

  if (GEN == 1) begin : g_clamp
    always_comb begin
      wdata_o = merged;
      if (idx_i == IDX_W'(PHY_STAT_IDX)) wdata_o[0] = 1'b0;
      if (idx_i == IDX_W'(SELFTEST_IDX)) begin
        wdata_o[12] = 1'b1;
        wdata_o[13] = 1'b0;
      end
    end
  end else begin : g_pass
    assign wdata_o = merged;
  end
endmodule

// File: rtl/memctl_cfg_bank.sv
module memctl_cfg_bank
  import memctl_cfg_pkg::*;
#(
  parameter int          NUM_REGS  = 64,
  parameter int          IDX_W     = 10,
  parameter logic [31:0] CONF_INIT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rd_word_o,
  output logic [31:0]      key_word_o,
  output logic [31:0]      conf_word_o
);
  logic [NUM_REGS-1:0][31:0] words;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    localparam logic [31:0] INIT = (i == CONF_IDX) ? CONF_INIT : 32'h0;
    logic [31:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= INIT;
      else if (we_i && idx_i == IDX_W'(i))     q <= wdata_i;
    end
    assign words[i] = q;
  end

  always_comb begin
    rd_word_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx_i == IDX_W'(i)) rd_word_o = words[i];
  end

  assign key_word_o  = words[0];
  assign conf_word_o = words[CONF_IDX];
endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
  import memctl_cfg_pkg::*;
#(
  parameter int GEN      = 1,
  parameter int RAM_MB   = 512,
  parameter int NUM_REGS = 64,
  parameter int ADDR_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_en_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  localparam int          IDX_W = ADDR_W - 2;
  localparam logic [31:0] FIXED = fixed_conf(GEN, RAM_MB);

  logic [IDX_W-1:0] idx;
  logic             in_range, is_key, unlocked, we;
  logic [31:0]      shaped, store_data, rd_word, key_word, conf_word;

  memctl_cfg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr_i     (addr_i),
    .idx_o      (idx),
    .in_range_o (in_range),
    .is_key_o   (is_key)
  );

  memctl_cfg_shape #(.GEN(GEN), .RAM_MB(RAM_MB), .IDX_W(IDX_W)) u_shape (
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .wdata_o (shaped)
  );

  assign unlocked   = |key_word;
  assign store_data = is_key ? {31'b0, wdata_i == UNLOCK_KEY} : shaped;
  assign we         = wr_en_i & in_range & (is_key | unlocked);

  memctl_cfg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CONF_INIT(FIXED)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we),
    .idx_i       (idx),
    .wdata_i     (store_data),
    .rd_word_o   (rd_word),
    .key_word_o  (key_word),
    .conf_word_o (conf_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= in_range ? rd_word : 32'h0;
      err_o <= (wr_en_i & (~in_range | (~is_key & ~unlocked))) | (rd_en_i & ~in_range);
    end
  end
endmodule

// File: rtl/memctl_cfg_regs_chk.sv
module memctl_cfg_regs_chk
  import memctl_cfg_pkg::*;
#(
  parameter int GEN      = 1,
  parameter int RAM_MB   = 512,
  parameter int NUM_REGS = 64,
  parameter int ADDR_W   = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wdata_i,
  input logic              rd_en_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic [31:0]       key_word_i,
  input logic [31:0]       conf_word_i
);
  localparam logic [31:0]       MASK  = ro_mask(GEN);
  localparam logic [31:0]       PIN   = fixed_conf(GEN, RAM_MB) & MASK;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] CONF  = ADDR_W'(CONF_IDX);

  logic [ADDR_W-1:0] word;
  assign word = addr_i >> 2;

  AST_KEY_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word == '0 && wdata_i == UNLOCK_KEY) |=> key_word_i == 32'd1); // R1
  AST_KEY_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word == '0 && wdata_i != UNLOCK_KEY) |=> key_word_i == 32'd0); // R1
  AST_LOCKED_CONF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word == CONF && key_word_i == 32'd0) |=> $stable(conf_word_i)); // R2
  AST_LOCKED_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word != '0 && word < LIMIT && key_word_i == 32'd0) |=> err_o); // R2

  if (GEN == 0) begin : g_old
    AST_CONF_PINNED_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conf_word_i & MASK) == PIN); // R3
  end else begin : g_new
    AST_CONF_PINNED_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conf_word_i & MASK) == PIN); // R4
  end

  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && word >= LIMIT) |=> rdata_o == 32'h0); // R9
  AST_OOR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_i || rd_en_i) && word >= LIMIT) |=> err_o); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R10
endmodule

bind memctl_cfg_regs memctl_cfg_regs_chk #(
  .GEN(GEN), .RAM_MB(RAM_MB), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .rd_en_i     (rd_en_i),
  .rdata_o     (rdata_o),
  .err_o       (err_o),
  .key_word_i  (key_word),
  .conf_word_i (conf_word)
);

// File: tb/sim_memctl_cfg_regs.sv
module sim_memctl_cfg_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int NR = 64;
  localparam logic [31:0] KEY = 32'hFC60_0309;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1, rd2, rd3, rd4;
  logic er0, er1, er2, er3, er4;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memctl_cfg_regs u0 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rd0), .err_o(er0));
  memctl_cfg_regs #(.GEN(0), .RAM_MB(100)) u1 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rd1), .err_o(er1));
  memctl_cfg_regs #(.GEN(1), .RAM_MB(1024)) u2 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rd2), .err_o(er2));
  memctl_cfg_regs #(.GEN(0), .RAM_MB(64)) u3 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rd3), .err_o(er3));
  memctl_cfg_regs #(.GEN(1), .RAM_MB(300)) u4 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rd4), .err_o(er4));

  int n_chk = 0, n_fail = 0;
  string cur_req = "R8";

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural model: index 0 = older generation (256MB fallback), 1 = newer (512MB)
  logic [31:0] m_regs [2][NR];
  logic [31:0] m_rd [2];
  logic        m_err [2];

  function automatic logic [31:0] shape(input int g, input int idx, input logic [31:0] d);
    logic [31:0] r = d;
    if (g == 0) begin
      if (idx == 1) r = (d & 32'h0000_07B3) | 32'h0000_0042;
    end else begin
      if (idx == 1)  r = (d & 32'h0FF0_3FB3) | 32'h1008_000E;
      if (idx == 24) r[0] = 1'b0;
      if (idx == 28) begin r[12] = 1'b1; r[13] = 1'b0; end
    end
    return r;
  endfunction

  task automatic m_reset();
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < NR; i++) m_regs[g][i] = '0;
      m_rd[g]  = '0;
      m_err[g] = 1'b0;
    end
    m_regs[0][1] = 32'h0000_0042;
    m_regs[1][1] = 32'h1008_000E;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      int  idx;
      bit  inr, open;
      idx = int'(addr >> 2);
      inr = idx < NR;
      for (int g = 0; g < 2; g++) begin
        open = inr && (m_regs[g][0] != 0);
        m_err[g] = (wr_en && (!inr || (idx != 0 && !open))) || (rd_en && !inr);
        if (rd_en) m_rd[g] = inr ? m_regs[g][idx] : 32'h0;
        if (wr_en && inr && (idx == 0 || open))
          m_regs[g][idx] = (idx == 0) ? {31'b0, wdata == KEY} : shape(g, idx, wdata);
      end
    end
  end

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      check(cur_req, rd0, m_rd[1], "u0 rdata vs model");
      check(cur_req, {31'b0, er0}, {31'b0, m_err[1]}, "u0 err vs model");
      check(cur_req, rd1, m_rd[0], "u1 rdata vs model");
      check(cur_req, {31'b0, er1}, {31'b0, m_err[0]}, "u1 err vs model");
    end
  end

  task automatic bus(input bit w, input bit r, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
  endtask
  task automatic idle();                                       bus(0, 0, '0, '0); endtask
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d); bus(1, 0, a, d);  endtask
  task automatic rd(input logic [AW-1:0] a);                   bus(0, 1, a, '0); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state, R6/R7 size codes
    cur_req = "R8";
    check("R8", rd0, 32'h0, "rdata after reset");
    check("R8", {31'b0, er0}, 32'h0, "err after reset");
    rd(12'h004); idle();
    check("R7", rd0, 32'h1008_000E, "u0 conf 512MB code 2");
    check("R6", rd1, 32'h0000_0042, "u1 conf fallback 256MB code 2");
    check("R7", rd2, 32'h1008_000F, "u2 conf 1024MB code 3");
    check("R6", rd3, 32'h0000_0040, "u3 conf 64MB code 0");
    check("R7", rd4, 32'h1008_000E, "u4 conf fallback 512MB code 2");
    rd(12'h000); idle();
    check("R8", rd0, 32'h0, "lock word after reset");
    rd(12'h060); idle();
    check("R8", rd0, 32'h0, "status word after reset");

    // R2 locked writes dropped, error pulse
    cur_req = "R2";
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h028, 32'h0000_1234);
    rd(12'h004); rd(12'h028); idle();
    check("R2", rd0, 32'h0, "locked write to word 10 dropped");
    wr(12'h014, 32'h1); idle();
    check("R2", {31'b0, er0}, 32'h1, "err after locked write");
    idle();
    check("R2", {31'b0, er0}, 32'h0, "err is a single pulse");

    // R1 key handling
    cur_req = "R1";
    wr(12'h000, 32'h1234_5678); rd(12'h000); idle();
    check("R1", rd0, 32'h0, "wrong key keeps lock");
    wr(12'h000, KEY); rd(12'h000); idle();
    check("R1", rd0, 32'h1, "key unlocks u0");
    check("R1", rd1, 32'h1, "key unlocks u1");

    // R3/R4 configuration merge
    cur_req = "R4";
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004); idle();
    check("R4", rd0, 32'h1FF8_3FBF, "newer conf all ones");
    check("R3", rd1, 32'h0000_07F3, "older conf all ones");
    wr(12'h004, 32'h0); rd(12'h004); idle();
    check("R4", rd0, 32'h1008_000E, "newer conf zero");
    check("R3", rd1, 32'h0000_0042, "older conf zero");
    cur_req = "R3";
    wr(12'h004, 32'hA5A5_A5A5); rd(12'h004); idle();

    // R5 status clamps
    cur_req = "R5";
    wr(12'h060, 32'hFFFF_FFFF); rd(12'h060); idle();
    check("R5", rd0, 32'hFFFF_FFFE, "newer PHY busy cleared");
    check("R5", rd1, 32'hFFFF_FFFF, "older status unchanged");
    wr(12'h070, 32'h0000_2000); rd(12'h070); idle();
    check("R5", rd0, 32'h0000_1000, "newer self-test done, no fail");
    check("R5", rd1, 32'h0000_2000, "older self-test unchanged");

    // R11 plain storage, low address bits ignored
    cur_req = "R11";
    wr(12'h028, 32'hDEAD_BEEF); rd(12'h028); idle();
    check("R11", rd0, 32'hDEAD_BEEF, "plain word stores data");
    wr(12'h00B, 32'h0000_0055); rd(12'h008); idle();
    check("R11", rd0, 32'h0000_0055, "addr bits 1:0 ignored");

    // R10 read timing
    cur_req = "R10";
    bus(1, 1, 12'h028, 32'h0000_1111); idle();
    check("R10", rd0, 32'hDEAD_BEEF, "same-cycle read returns old value");
    idle();
    check("R10", rd0, 32'hDEAD_BEEF, "rdata holds without rd_en");
    rd(12'h028); idle();
    check("R10", rd0, 32'h0000_1111, "write landed");

    // R9 out-of-range
    cur_req = "R9";
    wr(12'h100, 32'h0); idle();
    check("R9", {31'b0, er0}, 32'h1, "err on out-of-range write");
    rd(12'h000); idle();
    check("R9", rd0, 32'h1, "out-of-range write did not alias lock word");
    rd(12'h3FC); idle();
    check("R9", rd0, 32'h0, "out-of-range read is zero");
    check("R9", {31'b0, er0}, 32'h1, "err on out-of-range read");

    // random stream, lock toggling
    cur_req = "R2";
    for (int k = 0; k < 600; k++) begin
      logic [AW-1:0] a;
      logic [31:0]   d;
      case ($urandom % 7)
        0: a = 12'h000; 1: a = 12'h004; 2: a = 12'h060; 3: a = 12'h070;
        4: a = 12'h028; 5: a = 12'h104; default: a = 12'h0FC;
      endcase
      d = (($urandom % 4) == 0) ? KEY : $urandom;
      bus(1'($urandom % 2), 1'($urandom % 2), a, d);
    end
    idle();

    // R1 relock then conf write ignored
    cur_req = "R1";
    wr(12'h000, 32'h0); rd(12'h000); idle();
    check("R1", rd0, 32'h0, "relock stores 0");
    wr(12'h004, 32'h0000_0003); idle(); idle();

    // R8 reset mid-run
    cur_req = "R8";
    wr(12'h000, KEY); wr(12'h028, 32'h7777_7777); rd(12'h028); idle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R8", rd0, 32'h0, "rdata cleared by reset");
    check("R8", {31'b0, er0}, 32'h0, "err cleared by reset");
    rst_n = 1'b1;
    rd(12'h028); idle();
    check("R8", rd0, 32'h0, "word 10 cleared by reset");
    rd(12'h004); idle();
    check("R8", rd0, 32'h1008_000E, "conf reloaded by reset");
    wr(12'h028, 32'h1); rd(12'h028); idle();
    check("R8", rd0, 32'h0, "locked after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule